// File: doc/BRIEF.md
# Indirect wide-register mailbox bridge

This block lets a host with a 32-bit register window reach a bank of 64-bit registers inside a serial controller. The host cannot map the wide registers directly. It loads a 64-bit value in two halves, then writes a command word that holds an internal address and a direction flag. The bridge carries out that one access over several clock cycles, moves the result back into the two halves for a read, and keeps a sticky error flag that the host clears through a dedicated reset register.

The internal register bank is a small memory at a fixed base address. Any address outside that range fails, and so does an access made while the error-injection input is high. After each command finishes, an interrupt-pending flag is set. It stays set until the host clears it.

Host reads are combinational on the presented offset. Host writes take effect on the rising clock edge. Only one host write can occur per cycle.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, every host offset reads 0 and `irq_o` is 0. Offsets other than data-high (0x00), data-low (0x04), status (0x1C) and interrupt (0x20) always read 0. This includes the command (0x08) and reset (0x18) offsets.
- R2: Write flow. The host writes bits 63:32 to 0x00, then bits 31:0 to 0x04, then a command to 0x08 with bit 31 set. This stores the 64-bit value at the internal address given by command bits 30:0.
- R3: Read flow. A command with bit 31 clear reads the internal register. When the command finishes, bits 63:32 of the result appear at 0x00 and bits 31:0 appear at 0x04.
- R4: Status bit 0 (busy) reads 1 for exactly `ACCESS_LAT` cycles, starting in the cycle after the command write. The read result is visible in the first cycle in which busy reads 0.
- R5: While busy is set, writes to the command and data offsets are ignored.
- R6: An internal address outside [`BASE`, `BASE`+`NREGS`) sets status bit 31 (error). The data registers and the register bank stay unchanged.
- R7: If `err_inject` is high in the last busy cycle, the access fails in the same way as in R6.
- R8: The error bit stays set through later successful accesses.
- R9: Writing any value to 0x18 clears the error bit and both data registers. If a command is executing, it is abandoned: busy clears, the bank is not written, and no completion is flagged.
- R10: Interrupt register bit 0, which `irq_o` mirrors, is set by every completion, including a failed one. Writing any value to 0x20 clears it, but a completion in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | HOST_AW | Host byte offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_addr` |
| err_inject | input | 1 | Forces the executing access to fail |
| irq_o | output | 1 | Completion pending |

## Verification
The bench probes both edges of the address range: one below the base, the last valid entry, and one past the end. A decoder off by one would either corrupt a neighbouring register or flag a valid register as an error. It issues commands and data writes while busy is set; a design that let them through would report the wrong result or store an altered value. It writes the reset register in the middle of a command and clears the interrupt in the very cycle a command completes. A wrong priority would lose a completion or leave a stale write in the bank. Error injection during a write checks that a failed write leaves the stored value untouched.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int HOST_DW = 32;
  localparam int WIDE_DW = 64;

  localparam logic [5:0] OFS_DHI  = 6'h00;
  localparam logic [5:0] OFS_DLO  = 6'h04;
  localparam logic [5:0] OFS_CMD  = 6'h08;
  localparam logic [5:0] OFS_RST  = 6'h18;
  localparam logic [5:0] OFS_STAT = 6'h1C;
  localparam logic [5:0] OFS_IRQ  = 6'h20;

  localparam int CMD_WR_BIT    = 31;
  localparam int STAT_ERR_BIT  = 31;
  localparam int STAT_BUSY_BIT = 0;

  typedef struct packed {
    logic dhi;
    logic dlo;
    logic cmd;
    logic rst;
    logic irq;
  } wr_strobe_t;
endpackage

// File: rtl/wrb_host_dec.sv
module wrb_host_dec
  import wrb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                wr_en,
  input  logic [AW-1:0]       addr,
  input  logic [WIDE_DW-1:0]  stage,
  input  logic                err,
  input  logic                busy,
  input  logic                done,
  output wr_strobe_t          stb,
  output logic [HOST_DW-1:0]  rdata
);
  always_comb begin
    stb = '0;
    if (wr_en) begin
      case (addr)
        AW'(OFS_DHI): stb.dhi = 1'b1;
        AW'(OFS_DLO): stb.dlo = 1'b1;
        AW'(OFS_CMD): stb.cmd = 1'b1;
        AW'(OFS_RST): stb.rst = 1'b1;
        AW'(OFS_IRQ): stb.irq = 1'b1;
        default:      stb = '0;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(OFS_DHI):  rdata = stage[63:32];
      AW'(OFS_DLO):  rdata = stage[31:0];
      AW'(OFS_STAT): begin
        rdata[STAT_ERR_BIT]  = err;
        rdata[STAT_BUSY_BIT] = busy;
      end
      AW'(OFS_IRQ):  rdata[0] = done;
      default:       rdata = '0;
    endcase
  end
endmodule

// File: rtl/wrb_cmd_seq.sv
module wrb_cmd_seq
  import wrb_pkg::*;
#(
  parameter int          NREGS      = 16,
  parameter logic [30:0] BASE       = 31'h0007_0000,
  parameter int          ACCESS_LAT = 3,
  localparam int         IW         = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int         CW         = $clog2(ACCESS_LAT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wr_strobe_t         stb,
  input  logic [HOST_DW-1:0] wdata,
  input  logic               inject,
  input  logic [WIDE_DW-1:0] rd_word,
  output logic [WIDE_DW-1:0] stage,
  output logic               err,
  output logic               busy,
  output logic               done,
  output logic               acc_we,
  output logic [IW-1:0]      acc_idx,
  output logic [WIDE_DW-1:0] acc_wdata
);
  logic [WIDE_DW-1:0] stage_q, stage_d;
  logic               err_q, err_d;
  logic               busy_q, busy_d;
  logic               done_q, done_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic               dir_q;
  logic [30:0]        addr_q;
  logic               cmd_acc;
  logic [30:0]        offset;
  logic               hit;
  logic               finish;
  logic               fail;

  assign offset  = addr_q - BASE;
  assign hit     = (addr_q >= BASE) && (offset < 31'(NREGS));
  assign finish  = busy_q && (cnt_q == '0) && !stb.rst;
  assign fail    = !hit || inject;
  assign cmd_acc = stb.cmd && !busy_q;

  assign acc_we    = finish && dir_q && !fail;
  assign acc_idx   = offset[IW-1:0];
  assign acc_wdata = stage_q;

  always_comb begin
    stage_d = stage_q;
    err_d   = err_q;
    busy_d  = busy_q;
    done_d  = done_q;
    cnt_d   = cnt_q;
    if (stb.irq) done_d = 1'b0;
    if (stb.rst) begin
      stage_d = '0;
      err_d   = 1'b0;
      busy_d  = 1'b0;
      cnt_d   = '0;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        if (fail)        err_d   = 1'b1;
        else if (!dir_q) stage_d = rd_word;
      end else begin
        cnt_d = cnt_q - CW'(1);
      end
    end else begin
      if (stb.dhi) stage_d[63:32] = wdata;
      if (stb.dlo) stage_d[31:0]  = wdata;
      if (stb.cmd) begin
        busy_d = 1'b1;
        cnt_d  = CW'(ACCESS_LAT - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      err_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      stage_q <= stage_d;
      err_q   <= err_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      addr_q <= '0;
    end else if (cmd_acc) begin
      dir_q  <= wdata[CMD_WR_BIT];
      addr_q <= wdata[30:0];
    end
  end

  assign stage = stage_q;
  assign err   = err_q;
  assign busy  = busy_q;
  assign done  = done_q;

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (cnt_q != '0) && !stb.rst |=> busy_q); // R4
  AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (cnt_q != '0) && !stb.rst |=> $stable(stage_q)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && !stb.rst |=> err_q); // R8
  AST_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rst |=> !err_q && !busy_q && (stage_q == '0)); // R9
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && (cnt_q == '0) && !stb.rst |=> done_q); // R10
endmodule

// File: rtl/wrb_reg_store.sv
module wrb_reg_store
  import wrb_pkg::*;
#(
  parameter int  IW    = 4,
  localparam int DEPTH = 1 << IW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IW-1:0]      idx,
  input  logic [WIDE_DW-1:0] wdata,
  output logic [WIDE_DW-1:0] rdata
);
  logic [WIDE_DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (idx == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem[g] <= '0;
      else if (ent_en) mem[g] <= wdata;
    end
  end

  assign rdata = mem[idx];

  AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> rdata == $past(wdata)); // R2
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
  import wrb_pkg::*;
#(
  parameter int          HOST_AW    = 6,
  parameter int          NREGS      = 16,
  parameter logic [30:0] BASE       = 31'h0007_0000,
  parameter int          ACCESS_LAT = 3,
  localparam int         IW         = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               err_inject,
  output logic               irq_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_n_s;
  wr_strobe_t         stb;
  logic [WIDE_DW-1:0] stage;
  logic               err, busy, done;
  logic               acc_we;
  logic [IW-1:0]      acc_idx;
  logic [WIDE_DW-1:0] acc_wdata, rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  wrb_host_dec #(.AW(HOST_AW)) dec_i (
    .wr_en(host_wr), .addr(host_addr), .stage(stage), .err(err),
    .busy(busy), .done(done), .stb(stb), .rdata(host_rdata)
  );

  wrb_cmd_seq #(.NREGS(NREGS), .BASE(BASE), .ACCESS_LAT(ACCESS_LAT)) seq_i (
    .clk(clk), .rst_n(rst_n_s), .stb(stb), .wdata(host_wdata),
    .inject(err_inject), .rd_word(rd_word), .stage(stage), .err(err),
    .busy(busy), .done(done), .acc_we(acc_we), .acc_idx(acc_idx),
    .acc_wdata(acc_wdata)
  );

  wrb_reg_store #(.IW(IW)) store_i (
    .clk(clk), .rst_n(rst_n_s), .we(acc_we), .idx(acc_idx),
    .wdata(acc_wdata), .rdata(rd_word)
  );

  assign irq_o = done;
endmodule

// File: tb/wide_reg_bridge_tb_top.sv
module wide_reg_bridge_tb_top;
  localparam int          NREGS = 16;
  localparam logic [30:0] BASE  = 31'h0007_0000;
  localparam int          LAT   = 3;
  localparam logic [5:0]  A_DHI = 6'h00, A_DLO = 6'h04, A_CMD = 6'h08,
                          A_RST = 6'h18, A_STAT = 6'h1C, A_IRQ = 6'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        err_inject = 1'b0;
  logic        irq_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // behavioural reference state
  logic [31:0] m_hi, m_lo;
  bit          m_err, m_busy, m_done, m_dir;
  int          m_cnt;
  logic [30:0] m_addr;
  logic [63:0] mm [NREGS];

  always #2ns clk = ~clk;

  wide_reg_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .err_inject(err_inject), .irq_o(irq_o)
  );

  function automatic logic [31:0] m_read(logic [5:0] a);
    case (a)
      A_DHI:   return m_hi;
      A_DLO:   return m_lo;
      A_STAT:  return {m_err, 30'd0, m_busy};
      A_IRQ:   return {31'd0, m_done};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic m_update(bit we, logic [5:0] a, logic [31:0] d, bit inj);
    bit ok;
    int ix;
    if (we && a == A_IRQ) m_done = 0;
    if (we && a == A_RST) begin
      m_hi = 0; m_lo = 0; m_err = 0; m_busy = 0; m_cnt = 0;
    end else if (m_busy) begin
      if (m_cnt == 0) begin
        m_busy = 0;
        m_done = 1;
        ok = (m_addr >= BASE) && (m_addr < BASE + 31'(NREGS)) && !inj;
        ix = int'(m_addr - BASE);
        if (!ok) m_err = 1;
        else if (m_dir) mm[ix] = {m_hi, m_lo};
        else {m_hi, m_lo} = mm[ix];
      end else m_cnt--;
    end else if (we) begin
      if (a == A_DHI) m_hi = d;
      if (a == A_DLO) m_lo = d;
      if (a == A_CMD) begin
        m_busy = 1; m_cnt = LAT - 1; m_dir = d[31]; m_addr = d[30:0];
      end
    end
  endtask

  // one clock: drive at negedge, compare, then advance model at posedge
  task automatic step(bit we, logic [5:0] a, logic [31:0] d, bit inj, string req);
    @(negedge clk);
    host_wr = we; host_addr = a; host_wdata = d; err_inject = inj;
    #1ns;
    check(req, host_rdata, m_read(a));
    check({req, " irq"}, {31'd0, irq_o}, {31'd0, m_done});
    @(posedge clk);
    m_update(we, a, d, inj);
  endtask

  task automatic idle(int n, logic [5:0] a, bit inj, string req);
    for (int i = 0; i < n; i++) step(0, a, 32'd0, inj, req);
  endtask

  task automatic wr_wide(logic [30:0] ad, logic [63:0] v, bit inj, string req);
    step(1, A_DHI, v[63:32], 0, req);
    step(1, A_DLO, v[31:0], 0, req);
    step(1, A_CMD, {1'b1, ad}, 0, req);
    idle(LAT + 1, A_STAT, inj, req);
  endtask

  task automatic rd_wide(logic [30:0] ad, string req);
    step(1, A_CMD, {1'b0, ad}, 0, req);
    idle(LAT + 1, A_STAT, 0, req);
    step(0, A_DHI, 32'd0, 0, req);
    step(0, A_DLO, 32'd0, 0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_hi = 0; m_lo = 0; m_err = 0; m_busy = 0; m_done = 0; m_dir = 0;
    m_cnt = 0; m_addr = 0;
    for (int i = 0; i < NREGS; i++) mm[i] = 64'd0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset values at every offset, including write-only ones
    step(0, A_DHI, 0, 0, "R1"); step(0, A_DLO, 0, 0, "R1");
    step(0, A_CMD, 0, 0, "R1"); step(0, A_RST, 0, 0, "R1");
    step(0, A_STAT, 0, 0, "R1"); step(0, A_IRQ, 0, 0, "R1");
    step(0, 6'h10, 0, 0, "R1");

    // R2, R4: write two entries, busy polled each cycle
    wr_wide(BASE + 31'd3, 64'h0123_4567_89AB_CDEF, 0, "R2");
    wr_wide(BASE + 31'(NREGS - 1), 64'hFEDC_BA98_7654_3210, 0, "R2");
    step(0, A_CMD, 0, 0, "R1");

    // R3: read back, including top boundary entry
    rd_wide(BASE + 31'd3, "R3");
    rd_wide(BASE + 31'(NREGS - 1), "R3");
    rd_wide(BASE + 31'd0, "R3");

    // R10: clear pending completion, then clear in completion cycle
    step(1, A_IRQ, 32'hFFFF_FFFF, 0, "R10");
    step(0, A_IRQ, 0, 0, "R10");
    step(1, A_CMD, {1'b0, BASE + 31'd3}, 0, "R10");
    idle(LAT - 1, A_IRQ, 0, "R10");
    step(1, A_IRQ, 32'd1, 0, "R10");
    step(0, A_IRQ, 0, 0, "R10");
    step(1, A_IRQ, 32'd0, 0, "R10");

    // R5: command and data writes during busy are dropped
    step(1, A_DHI, 32'hAAAA_0001, 0, "R5");
    step(1, A_DLO, 32'hAAAA_0002, 0, "R5");
    step(1, A_CMD, {1'b1, BASE + 31'd5}, 0, "R5");
    step(1, A_DLO, 32'h5555_5555, 0, "R5");
    step(1, A_CMD, {1'b1, BASE + 31'd6}, 0, "R5");
    idle(LAT, A_DLO, 0, "R5");
    rd_wide(BASE + 31'd5, "R5");
    rd_wide(BASE + 31'd6, "R5");

    // R6: out of range below, above; data kept
    rd_wide(BASE + 31'(NREGS), "R6");
    step(1, A_RST, 32'd0, 0, "R9");
    step(1, A_DHI, 32'h1111_2222, 0, "R6");
    step(1, A_DLO, 32'h3333_4444, 0, "R6");
    rd_wide(BASE - 31'd1, "R6");
    wr_wide(BASE + 31'(NREGS), 64'h9999_9999_9999_9999, 0, "R6");

    // R8: error persists through a good access
    rd_wide(BASE + 31'd3, "R8");
    step(0, A_STAT, 0, 0, "R8");

    // R9: reset register clears error and data
    step(1, A_RST, 32'h1234_5678, 0, "R9");
    step(0, A_STAT, 0, 0, "R9"); step(0, A_DHI, 0, 0, "R9");
    step(0, A_DLO, 0, 0, "R9");

    // R7: injected failure on write leaves bank entry intact
    wr_wide(BASE + 31'd3, 64'hDEAD_BEEF_DEAD_BEEF, 1, "R7");
    step(1, A_RST, 32'd0, 0, "R9");
    rd_wide(BASE + 31'd3, "R7");
    step(1, A_RST, 32'd0, 0, "R9");
    step(1, A_IRQ, 32'd0, 0, "R10");

    // R9: reset mid-command abandons it
    step(1, A_DHI, 32'hCAFE_0000, 0, "R9");
    step(1, A_DLO, 32'h0000_CAFE, 0, "R9");
    step(1, A_CMD, {1'b1, BASE + 31'd7}, 0, "R9");
    step(0, A_STAT, 0, 0, "R9");
    step(1, A_RST, 32'd0, 0, "R9");
    idle(LAT + 1, A_STAT, 0, "R9");
    step(0, A_IRQ, 0, 0, "R9");
    rd_wide(BASE + 31'd7, "R9");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule